// File: doc/BRIEF.md
# Radius-Adjusted Blind Equalizer Error Unit

This block sits beside the tap filter of a blind QAM equalizer and turns each complex output sample into the error term and step size used by the tap update. It is fed one sample per symbol, with I and Q as signed fixed-point values. It finds the nearest square-QAM symbol for the sample and measures how far the sample lies from that symbol. The squared distance is compared against circular contours centred on the symbol to choose a region. The region sets the step size and the blend between a multimodulus error and a second error criterion. That second criterion is either a constellation-matched pull toward the symbol or the plain decision-directed error, chosen by a mode input.

Regions close to a symbol can take a small step and lean on the decision-directed error. Regions far from every symbol can lean on the multimodulus error. Any region can also be set to suppress the update, which allows the taps to be updated selectively by radius. The result leaves a three-stage pipeline with a valid strobe and an update-enable flag, and a new symbol can be accepted every cycle.

Top module: `rae_error_unit`

## Requirements
- R1: On each rail the slicer picks the level 16·(2k+1) nearest to the sample, for integer k. A sample exactly midway between two levels goes to the upper one. The level is clamped to ±16·(L−1) with L = 2^(cfg_qam+1), so cfg_qam values 0, 1, 2 and 3 select 4-, 16-, 64- and 256-QAM.
- R2: The decision-directed error on each rail is the sample minus its sliced level.
- R3: The multimodulus error on each rail is (y·(q − D)) >>> 4, where q = (y·y) >> 8. D is 1, 8, 37 or 152 for cfg_qam 0, 1, 2 and 3.
- R4: The constellation-matched error on each rail is +16 when the decision-directed error is positive, −16 when it is negative, and 0 when it is zero.
- R5: The squared distance is the sum of the two squared decision-directed errors. The region is the number of the three cfg_thr entries that this distance equals or exceeds, so a distance equal to a threshold counts as beyond it. The region appears on err_region.
- R6: With w = cfg_wgt[region], the blend is w·multimodulus + (16 − w)·alt. When cfg_mode is 0, alt is the constellation-matched error. When cfg_mode is 1, alt is the decision-directed error.
- R7: The blend is scaled by an arithmetic right shift of 4 + cfg_shift[region], which rounds toward minus infinity.
- R8: The scaled error saturates to the signed 16-bit range [−32768, 32767].
- R9: When cfg_gate[region] is 1, the symbol still gives err_vld high and its region. In that case upd_en is low and err_i and err_q are zero. Otherwise upd_en is high.
- R10: A symbol presented with in_vld high appears with err_vld high exactly three rising edges later, counting the edge that samples it. Symbols may arrive on consecutive cycles.
- R11: In a cycle with err_vld low, err_i, err_q, err_region and upd_en are all zero.
- R12: While rst_n is low at a rising edge, every output is cleared to zero on that edge.
- Configuration inputs must stay unchanged while a symbol is in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Equalizer output sample valid |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| cfg_qam | input | 2 | QAM order select |
| cfg_mode | input | 1 | Second criterion: 0 constellation-matched, 1 decision-directed |
| cfg_thr | input | 3×27 | Squared contour thresholds, entry k at bits 27k+26:27k |
| cfg_shift | input | 4×4 | Extra right shift per region |
| cfg_wgt | input | 4×4 | Multimodulus weight per region, in sixteenths |
| cfg_gate | input | 4 | Per-region update suppression |
| err_vld | output | 1 | Error valid strobe |
| err_i | output | 16 | In-phase scaled error, signed |
| err_q | output | 16 | Quadrature scaled error, signed |
| upd_en | output | 1 | Tap update enable |
| err_region | output | 2 | Region chosen for this symbol |

## Verification
The bench targets the slicer at its midpoints and at the clamp. A slicer that rounds ties the wrong way, or that forgets the clamp for small orders, gives decision errors off by 32 or in the thousands. A sample placed so that the squared distance equals a threshold catches a strict comparison, which would report the region one too low. Samples at full scale with weight 15 and no shift must saturate; logic that wraps instead would flip the sign of the error. The bench also gates the regions, mixes the two modes, and alternates valid and idle cycles. These cases expose an error that leaks through a suppressed update, a swapped criterion, or a result that lands one cycle early or late.

// File: rtl/rae_pkg.sv
// Shared definitions for the radius-adjusted error unit.
// Assumes the grid unit and weight format that rae_error_unit parameters describe.
package rae_pkg;

    // Selects the criterion blended with the multimodulus error
    typedef enum logic {
        MIX_CM = 1'b0,   // constellation-matched pull toward the symbol
        MIX_DD = 1'b1    // decision-directed error
    } mix_mode_e;

    // Dispersion constant per QAM order, in units of the squared grid step
    function automatic logic [7:0] disp_const(input logic [1:0] order);
        case (order)
            2'd0:    return 8'd1;
            2'd1:    return 8'd8;
            2'd2:    return 8'd37;
            default: return 8'd152;
        endcase
    endfunction

endpackage

// File: rtl/rae_slicer.sv
// Per-rail slicer: finds the nearest odd grid level (ties upward), clamps it to
// the constellation edge for the selected order, and forms the decision error
// and the scaled square of the sample. Purely combinational; clk/rst_n feed
// only the assertion. Assumes the grid step is 2**GS LSBs and the largest level fits DW bits.
module rae_slicer #(
    parameter int DW = 12,
    parameter int GS = 4,
    localparam int SQW = 2*DW - 2*GS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] y,
    input  logic [1:0]           order,
    output logic signed [DW:0]   dd,
    output logic [SQW-1:0]       sq
);

    logic signed [DW-1:0]   idx;
    logic signed [DW-1:0]   lvl;
    logic signed [DW-1:0]   lim;
    logic signed [DW-1:0]   lvl_c;
    logic signed [DW-1:0]   sliced;
    logic signed [2*DW-1:0] prod;

    // Nearest odd level, clamp, decision error and scaled square
    always_comb begin
        idx    = y >>> (GS + 1);
        lvl    = DW'(idx * 2 + 1);
        lim    = DW'((2 << order) - 1);
        if (lvl > lim)
            lvl_c = lim;
        else if (lvl < -lim)
            lvl_c = -lim;
        else
            lvl_c = lvl;
        sliced = lvl_c <<< GS;
        dd     = (DW+1)'(y) - (DW+1)'(sliced);
        prod   = y * y;
        sq     = SQW'(prod >> (2*GS));
    end

    logic signed [DW:0] y_ext;
    logic signed [DW:0] y_mag;
    logic               in_range;

    // Magnitude test used by the nearness check below
    always_comb begin
        y_ext    = (DW+1)'(y);
        y_mag    = y_ext[DW] ? -y_ext : y_ext;
        in_range = y_mag < (DW+1)'((2 << order) << GS);
    end

    AST_SLICE_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> (dd <= (DW+1)'(1 << GS) && dd >= -(DW+1)'(1 << GS))); // R1

endmodule

// File: rtl/rae_region.sv
// Region selector: squares the two decision errors, sums them and counts how
// many contour thresholds the sum meets or exceeds. Assumes NREG is a power of
// two so the count fits RW bits. Combinational.
module rae_region #(
    parameter int DW   = 12,
    parameter int NREG = 4,
    localparam int D2W = 2*DW + 3,
    localparam int RW  = $clog2(NREG)
) (
    input  logic signed [DW:0]           dd_i,
    input  logic signed [DW:0]           dd_q,
    input  logic [NREG-2:0][D2W-1:0]     thr,
    output logic [RW-1:0]                region
);

    logic signed [2*DW+1:0] sq_i;
    logic signed [2*DW+1:0] sq_q;
    logic [D2W-1:0]         d2;
    logic [NREG-2:0]        met;

    // Squared distance from the sliced symbol
    always_comb begin
        sq_i = dd_i * dd_i;
        sq_q = dd_q * dd_q;
        d2   = D2W'(unsigned'(sq_i)) + D2W'(unsigned'(sq_q));
    end

    // One comparator per contour
    for (genvar k = 0; k < NREG-1; k++) begin : g_cmp
        assign met[k] = (d2 >= thr[k]);
    end

    // Region index is the number of contours crossed
    always_comb begin
        region = '0;
        for (int k = 0; k < NREG-1; k++)
            region = region + RW'(met[k]);
    end

endmodule

// File: rtl/rae_mix.sv
// Per-rail blender: weights the multimodulus term by wgt/2**WB and the other
// term by the remainder, applies the region's power-of-two step as an
// arithmetic right shift, and saturates to OW bits. Combinational.
module rae_mix #(
    parameter int MW  = 30,
    parameter int OW  = 16,
    parameter int WB  = 4,
    parameter int SHW = 4,
    localparam int AW = MW + WB + 2
) (
    input  logic signed [MW-1:0] crit_a,
    input  logic signed [MW-1:0] crit_b,
    input  logic [WB-1:0]        wgt,
    input  logic [SHW-1:0]       step_sh,
    output logic signed [OW-1:0] res
);

    localparam logic signed [AW-1:0] SAT_HI = AW'((64'sd1 <<< (OW-1)) - 64'sd1);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

    logic [WB:0]            wgt_b;
    logic signed [AW-1:0]   acc;
    logic signed [AW-1:0]   scaled;

    // Weighted sum, step shift and saturation
    always_comb begin
        wgt_b  = (WB+1)'(1 << WB) - (WB+1)'(wgt);
        acc    = crit_a * $signed({1'b0, wgt}) + crit_b * $signed({1'b0, wgt_b});
        scaled = acc >>> (WB + int'(step_sh));
        if (scaled > SAT_HI)
            res = SAT_HI[OW-1:0];
        else if (scaled < SAT_LO)
            res = SAT_LO[OW-1:0];
        else
            res = scaled[OW-1:0];
    end

endmodule

// File: rtl/rae_error_unit.sv
// Radius-adjusted blind equalizer error unit. Stage 1 slices each rail and
// registers decision error and scaled square; stage 2 forms the multimodulus
// and alternate criteria and the region; stage 3 blends, shifts, saturates and
// applies region gating. Assumes configuration is steady while symbols are in flight.
module rae_error_unit #(
    parameter int DW   = 12,
    parameter int GS   = 4,
    parameter int OW   = 16,
    parameter int MS   = 4,
    parameter int NREG = 4,
    parameter int WB   = 4,
    parameter int SHW  = 4,
    localparam int SQW = 2*DW - 2*GS,
    localparam int D2W = 2*DW + 3,
    localparam int RW  = $clog2(NREG),
    localparam int MW  = DW + SQW + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic signed [DW-1:0]         in_i,
    input  logic signed [DW-1:0]         in_q,
    input  logic [1:0]                   cfg_qam,
    input  logic                         cfg_mode,
    input  logic [NREG-2:0][D2W-1:0]     cfg_thr,
    input  logic [NREG-1:0][SHW-1:0]     cfg_shift,
    input  logic [NREG-1:0][WB-1:0]      cfg_wgt,
    input  logic [NREG-1:0]              cfg_gate,
    output logic                         err_vld,
    output logic signed [OW-1:0]         err_i,
    output logic signed [OW-1:0]         err_q,
    output logic                         upd_en,
    output logic [RW-1:0]                err_region
);

    localparam logic signed [MW-1:0] UNIT = MW'(1 << GS);

    logic signed [DW-1:0]  y0  [2];
    logic signed [DW:0]    dd0 [2];
    logic [SQW-1:0]        sq0 [2];

    logic                  v1;
    logic signed [DW-1:0]  y1  [2];
    logic signed [DW:0]    dd1 [2];
    logic [SQW-1:0]        sq1 [2];

    logic [7:0]            disp;
    logic signed [MW-1:0]  mma_c [2];
    logic signed [MW-1:0]  alt_c [2];
    logic [RW-1:0]         reg_c;

    logic                  v2;
    logic signed [MW-1:0]  mma2 [2];
    logic signed [MW-1:0]  alt2 [2];
    logic [RW-1:0]         reg2;

    logic signed [OW-1:0]  res3 [2];
    logic                  gate3;

    assign y0[0] = in_i;
    assign y0[1] = in_q;
    assign disp  = rae_pkg::disp_const(cfg_qam);

    for (genvar r = 0; r < 2; r++) begin : g_rail
        logic signed [SQW+1:0] qmr;
        logic signed [MW-1:0]  prod;

        rae_slicer #(.DW(DW), .GS(GS)) i_slicer (
            .clk   (clk),
            .rst_n (rst_n),
            .y     (y0[r]),
            .order (cfg_qam),
            .dd    (dd0[r]),
            .sq    (sq0[r])
        );

        // Stage 1 register: sample, decision error and scaled square
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                y1[r]  <= '0;
                dd1[r] <= '0;
                sq1[r] <= '0;
            end else begin
                y1[r]  <= y0[r];
                dd1[r] <= dd0[r];
                sq1[r] <= sq0[r];
            end
        end

        // Multimodulus error and the mode-selected alternate criterion
        always_comb begin
            qmr      = (SQW+2)'(sq1[r]) - (SQW+2)'(disp);
            prod     = y1[r] * qmr;
            mma_c[r] = prod >>> MS;
            if (rae_pkg::mix_mode_e'(cfg_mode) == rae_pkg::MIX_DD)
                alt_c[r] = MW'(dd1[r]);
            else if (dd1[r] == '0)
                alt_c[r] = '0;
            else if (dd1[r][DW])
                alt_c[r] = -UNIT;
            else
                alt_c[r] = UNIT;
        end

        // Stage 2 register: both criteria
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mma2[r] <= '0;
                alt2[r] <= '0;
            end else begin
                mma2[r] <= mma_c[r];
                alt2[r] <= alt_c[r];
            end
        end

        rae_mix #(.MW(MW), .OW(OW), .WB(WB), .SHW(SHW)) i_mix (
            .crit_a  (mma2[r]),
            .crit_b  (alt2[r]),
            .wgt     (cfg_wgt[reg2]),
            .step_sh (cfg_shift[reg2]),
            .res     (res3[r])
        );
    end

    rae_region #(.DW(DW), .NREG(NREG)) i_region (
        .dd_i   (dd1[0]),
        .dd_q   (dd1[1]),
        .thr    (cfg_thr),
        .region (reg_c)
    );

    assign gate3 = cfg_gate[reg2];

    // Valid pipeline and stage 2 region register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            v2   <= 1'b0;
            reg2 <= '0;
        end else begin
            v1   <= in_vld;
            v2   <= v1;
            reg2 <= reg_c;
        end
    end

    // Output register: gated, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_vld    <= 1'b0;
            upd_en     <= 1'b0;
            err_region <= '0;
            err_i      <= '0;
            err_q      <= '0;
        end else begin
            err_vld    <= v2;
            upd_en     <= v2 && !gate3;
            err_region <= v2 ? reg2 : '0;
            err_i      <= (v2 && !gate3) ? res3[0] : '0;
            err_q      <= (v2 && !gate3) ? res3[1] : '0;
        end
    end

    AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##3 err_vld); // R10
    AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##3 !err_vld); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |-> (err_i == '0 && err_q == '0 && !upd_en && err_region == '0)); // R11
    AST_GATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !upd_en) |-> (err_i == '0 && err_q == '0)); // R9

endmodule

// File: tb/test_rae_error_unit.sv
module test_rae_error_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic   v;
        longint ei;
        longint eq;
        logic   up;
        int     rg;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [11:0]       in_i = '0;
    logic [11:0]       in_q = '0;
    logic [1:0]        cfg_qam = '0;
    logic              cfg_mode = 1'b0;
    logic [2:0][26:0]  cfg_thr = '0;
    logic [3:0][3:0]   cfg_shift = '0;
    logic [3:0][3:0]   cfg_wgt = '0;
    logic [3:0]        cfg_gate = '0;
    logic              err_vld;
    logic [15:0]       err_i;
    logic [15:0]       err_q;
    logic              upd_en;
    logic [1:0]        err_region;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R3 R6 R7";
    exp_t  pipe [3];

    rae_error_unit i_rae_error_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .cfg_qam(cfg_qam), .cfg_mode(cfg_mode), .cfg_thr(cfg_thr),
        .cfg_shift(cfg_shift), .cfg_wgt(cfg_wgt), .cfg_gate(cfg_gate),
        .err_vld(err_vld), .err_i(err_i), .err_q(err_q), .upd_en(upd_en),
        .err_region(err_region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint disp(input logic [1:0] o);
        case (o)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 37;
            default: return 152;
        endcase
    endfunction

    // Expected output for one symbol, from the requirements
    function automatic exp_t model(input logic v, input logic [11:0] ri, input logic [11:0] rq);
        exp_t   e;
        longint y [2];
        longint dd [2];
        longint mm [2];
        longint al [2];
        longint d2;
        int     rg;
        int     w;
        int     sh;
        e = '{v: 1'b0, ei: 0, eq: 0, up: 1'b0, rg: 0};
        if (!v) return e;
        y[0] = longint'($signed(ri));
        y[1] = longint'($signed(rq));
        d2 = 0;
        for (int r = 0; r < 2; r++) begin
            longint idx, lvl, lim, q;
            idx = y[r] >>> 5;
            lvl = 2 * idx + 1;
            lim = longint'((2 << cfg_qam) - 1);
            if (lvl > lim) lvl = lim;
            if (lvl < -lim) lvl = -lim;
            dd[r] = y[r] - 16 * lvl;
            q = (y[r] * y[r]) >>> 8;
            mm[r] = (y[r] * (q - disp(cfg_qam))) >>> 4;
            if (cfg_mode) al[r] = dd[r];
            else al[r] = (dd[r] > 0) ? 16 : ((dd[r] < 0) ? -16 : 0);
            d2 += dd[r] * dd[r];
        end
        rg = 0;
        for (int k = 0; k < 3; k++)
            if (d2 >= longint'(cfg_thr[k])) rg++;
        w  = int'(cfg_wgt[rg]);
        sh = int'(cfg_shift[rg]);
        for (int r = 0; r < 2; r++) begin
            longint acc, s;
            acc = longint'(w) * mm[r] + longint'(16 - w) * al[r];
            s = acc >>> (4 + sh);
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            if (cfg_gate[rg]) s = 0;
            if (r == 0) e.ei = s; else e.eq = s;
        end
        e.v  = 1'b1;
        e.up = !cfg_gate[rg];
        e.rg = rg;
        return e;
    endfunction

    // Reference pipeline
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) pipe[k] <= '{v: 1'b0, ei: 0, eq: 0, up: 1'b0, rg: 0};
        end else begin
            pipe[2] <= pipe[1];
            pipe[1] <= pipe[0];
            pipe[0] <= model(in_vld, in_i, in_q);
        end
    end

    task automatic chk(input string t, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    // Check outputs at the falling edge, then drive the next input
    task automatic step(input logic v, input int yi, input int yq);
        @(negedge clk);
        chk("R10 err_vld", longint'(err_vld), longint'(pipe[2].v));
        if (pipe[2].v) begin
            chk({tag, " err_i"}, longint'($signed(err_i)), pipe[2].ei);
            chk({tag, " err_q"}, longint'($signed(err_q)), pipe[2].eq);
            chk("R9 upd_en", longint'(upd_en), longint'(pipe[2].up));
            chk("R5 err_region", longint'(err_region), longint'(pipe[2].rg));
        end else begin
            chk("R11 idle outputs", longint'({err_i, err_q, upd_en, err_region}), 0);
        end
        in_vld = v;
        in_i = 12'(yi);
        in_q = 12'(yq);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0);
    endtask

    function automatic int rand_sample();
        int lv;
        if ($urandom_range(0, 9) < 7) begin
            lv = 2 * int'($urandom_range(0, 15)) - 15;
            return lv * 16 + int'($urandom_range(0, 48)) - 24;
        end
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    task automatic rand_cfg();
        int t [3];
        int tmp;
        for (int k = 0; k < 3; k++) t[k] = int'($urandom_range(0, 1500));
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2 - a; b++)
                if (t[b] > t[b+1]) begin tmp = t[b]; t[b] = t[b+1]; t[b+1] = tmp; end
        for (int k = 0; k < 3; k++) cfg_thr[k] = 27'(t[k]);
        for (int k = 0; k < 4; k++) begin
            cfg_shift[k] = 4'($urandom_range(0, 9));
            cfg_wgt[k]   = 4'($urandom_range(0, 15));
        end
        cfg_gate = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
        cfg_qam  = 2'($urandom_range(0, 3));
        cfg_mode = 1'($urandom_range(0, 1));
    endtask

    task automatic plain_cfg(input logic [1:0] q, input logic m, input logic [3:0] w);
        cfg_qam = q;
        cfg_mode = m;
        for (int k = 0; k < 3; k++) cfg_thr[k] = 27'h7FFFFFF;
        for (int k = 0; k < 4; k++) begin cfg_shift[k] = 4'd0; cfg_wgt[k] = w; end
        cfg_gate = 4'd0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240517));
        for (int k = 0; k < 3; k++) pipe[k] = '{v: 1'b0, ei: 0, eq: 0, up: 1'b0, rg: 0};
        plain_cfg(2'd1, 1'b1, 4'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset outputs", longint'({err_vld, err_i, err_q, upd_en, err_region}), 0);
        rst_n = 1'b1;

        // R1 R2: weight 0, DD mode, no shift -> output equals decision error
        tag = "R1 R2";
        step(1, 0, -1); step(1, 32, -32); step(1, 16, -16);
        step(1, 2047, -2048); step(1, 63, 64); step(1, -33, 100);
        idle(4);
        plain_cfg(2'd0, 1'b1, 4'd0);
        step(1, 2047, -2048); step(1, 0, 31); step(1, -17, 500);
        idle(4);

        // R4: constellation-matched term only
        tag = "R4";
        plain_cfg(2'd2, 1'b0, 4'd0);
        step(1, 16, 48); step(1, 20, -20); step(1, -5, 5); step(1, 112, -112);
        idle(4);

        // R3: weight 15 on multimodulus term
        tag = "R3 R6";
        plain_cfg(2'd3, 1'b1, 4'd15);
        step(1, 100, -200); step(1, 240, 240); step(1, 1000, -7); step(1, -150, 33);
        idle(4);

        // R8: full-scale samples saturate
        tag = "R8";
        plain_cfg(2'd0, 1'b1, 4'd15);
        step(1, 2047, -2048); step(1, 2047, 2047); step(1, -2048, -2048);
        idle(4);

        // R5 R7: threshold boundaries and per-region shift
        tag = "R5 R7";
        plain_cfg(2'd3, 1'b1, 4'd0);
        cfg_thr[0] = 27'd100; cfg_thr[1] = 27'd400; cfg_thr[2] = 27'd900;
        for (int k = 0; k < 4; k++) cfg_shift[k] = 4'(k);
        step(1, 21, 16); step(1, 26, 16); step(1, 22, 24); step(1, 31, 31);
        step(1, 32, 32); step(1, 16, 25);
        idle(4);
        cfg_qam = 2'd0;
        step(1, 100, 16); step(1, -300, 16);
        idle(4);

        // R9: gated regions
        tag = "R9";
        cfg_qam = 2'd3;
        cfg_gate = 4'b1010;
        step(1, 21, 16); step(1, 26, 16); step(1, 31, 31); step(1, 16, 16);
        idle(4);

        // R3 R5 R6 R7 R8 R9 R10: random configuration and samples
        tag = "R3 R5 R6 R7 R10";
        for (int b = 0; b < 40; b++) begin
            rand_cfg();
            for (int s = 0; s < 60; s++) begin
                if (b % 4 == 3) step(1'($urandom_range(0, 1)), rand_sample(), rand_sample());
                else step(1'b1, rand_sample(), rand_sample());
            end
            idle(4);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule